// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block handles the control-flow side of taking and leaving an exception in a small 32-bit in-order core. When the core raises an exception it presents a cause number, the PC of the faulting instruction, a flag saying whether that instruction sat in a branch delay slot, and the live status word. In the following cycle the block computes the PC to resume at, keeps a shadow copy of the status word, and hands the core a new status word in which the delay-slot marker is set or cleared. It then issues a fetch redirect to the handler for that cause.

The handler address is the cause number shifted left by eight bits. That value sits on top of either a low base of zero or a high base of `0xF000_0000`, and a bit of the live status word picks the base. A breakpoint trap does not enter a handler. Instead it raises a halt pulse carrying the PC. An unknown cause raises an error pulse and changes no state. A return-from-exception strobe gives back the shadow status word and sends fetch to the saved PC. Flushing the pipeline and running the handler code are left to the core.

Top module: `excEntryCtl`

## Requirements
- R1: A supported entry cause (0x02 to 0x0D) produces `redirectValid` high for one cycle, one clock after the request. `redirectPc` is then the cause shifted left by 8, plus 0xF000_0000 when bit 14 of `statusIn` is 1 and plus zero when that bit is 0.
- R2: On entry, `esrOut` takes the full value of `statusIn` presented with the request.
- R3: On entry, `statusWe` pulses with `redirectValid`. `statusWrData` equals `statusIn` with bit 13 replaced by `excInDelay`.
- R4: On entry, `epcOut` becomes `excPc + 4` for the resume-after causes 0x05, 0x08 and 0x0B, and `excPc` for every other entry cause. A further 4 is subtracted when `excInDelay` is 1.
- R5: Cause 0x07 (illegal instruction) also loads `eearOut` with `excPc`. No other cause changes `eearOut`.
- R6: Cause 0x0E (trap) pulses `haltValid` with `haltPc = excPc`. It asserts no redirect and no status write, and leaves `epcOut` and `esrOut` unchanged.
- R7: Causes 0x00, 0x01 and 0x0F to 0x1F pulse `causeErr`. They assert no redirect, halt or status write, and change none of `epcOut`, `esrOut` and `eearOut`.
- R8: `rfeReq` on its own produces, one clock later, `redirectValid` with `redirectPc = epcOut`, and `statusWe` with `statusWrData = esrOut`.
- R9: `delayClr` pulses together with every entry redirect and every return redirect, and at no other time.
- R10: When `excReq` and `rfeReq` arrive in the same cycle, the return is ignored and only the exception request takes effect.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception request |
| excCause | input | 5 | Exception cause number |
| excPc | input | 32 | PC of the faulting instruction |
| excInDelay | input | 1 | Faulting instruction is in a delay slot |
| statusIn | input | 32 | Live status word |
| rfeReq | input | 1 | Return-from-exception strobe |
| redirectValid | output | 1 | Fetch redirect pulse |
| redirectPc | output | 32 | Fetch redirect target |
| statusWe | output | 1 | Status write-back pulse |
| statusWrData | output | 32 | Status value to write back |
| delayClr | output | 1 | Clear pending delay-slot state |
| haltValid | output | 1 | Trap halt pulse |
| haltPc | output | 32 | PC reported with the halt |
| causeErr | output | 1 | Unsupported cause pulse |
| epcOut | output | 32 | Saved exception PC |
| esrOut | output | 32 | Shadow status word |
| eearOut | output | 32 | Effective-address register |

## Verification
The hardest case to reach from the ports is a return that collides with an exception request. Both strobes have to be raised in the same cycle, and the return must still be visibly dropped. The bench drives that collision directly, once with a good cause and once with a bad cause. The bad cause is the revealing one: a leaked return would show up as a redirect. Random traffic also mixes delay-slot and resume-after causes under both vector bases. This covers all four PC adjustments, with returns placed in between so that each saved PC is read back through the redirect.

// File: rtl/excPkg.sv
package excPkg;
  typedef struct packed {
    logic entry;
    logic rfe;
    logic trap;
    logic bad;
    logic illegal;
    logic resume;
  } excStrobe_t;
endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
#(
  parameter int CAUSE_W = 5,
  parameter int CAUSE_MIN = 2,
  parameter int CAUSE_MAX = 13,
  parameter int CAUSE_TRAP = 14,
  parameter int CAUSE_ILLEGAL = 7,
  parameter int CAUSE_RES0 = 5,
  parameter int CAUSE_RES1 = 8,
  parameter int CAUSE_RES2 = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excReq,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic               rfeReq,
  output excStrobe_t         strobe,
  output logic               redirectValid,
  output logic               statusWe,
  output logic               delayClr,
  output logic               haltValid,
  output logic               causeErr
);
  localparam logic [CAUSE_W-1:0] cMin  = CAUSE_W'(CAUSE_MIN);
  localparam logic [CAUSE_W-1:0] cMax  = CAUSE_W'(CAUSE_MAX);
  localparam logic [CAUSE_W-1:0] cTrap = CAUSE_W'(CAUSE_TRAP);
  localparam logic [CAUSE_W-1:0] cIll  = CAUSE_W'(CAUSE_ILLEGAL);

  logic inRange;
  logic isTrap;

  always_comb begin
    inRange = (excCause >= cMin) && (excCause <= cMax);
    isTrap  = (excCause == cTrap);
    strobe.entry   = excReq && inRange;
    strobe.trap    = excReq && isTrap;
    strobe.bad     = excReq && !inRange && !isTrap;
    strobe.rfe     = rfeReq && !excReq;
    strobe.illegal = excReq && (excCause == cIll);
    strobe.resume  = (excCause == CAUSE_W'(CAUSE_RES0)) ||
                     (excCause == CAUSE_W'(CAUSE_RES1)) ||
                     (excCause == CAUSE_W'(CAUSE_RES2));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectValid <= 1'b0;
      statusWe      <= 1'b0;
      delayClr      <= 1'b0;
      haltValid     <= 1'b0;
      causeErr      <= 1'b0;
    end else begin
      redirectValid <= strobe.entry || strobe.rfe;
      statusWe      <= strobe.entry || strobe.rfe;
      delayClr      <= strobe.entry || strobe.rfe;
      haltValid     <= strobe.trap;
      causeErr      <= strobe.bad;
    end
  end

  // Only one kind of outcome per request.
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({redirectValid, haltValid, causeErr}));

  // A return colliding with a bad cause must not redirect (R10).
  assert_rfe_dropped_R10: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && rfeReq && !inRange) |=> !redirectValid);

  // Trap never redirects.
  assert_trap_no_redirect_R6: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && isTrap) |=> (haltValid && !statusWe));
endmodule

// File: rtl/excDatapath.sv
module excDatapath
  import excPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SR_W = 32,
  parameter int CAUSE_W = 5,
  parameter int VEC_SHIFT = 8,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hF000_0000,
  parameter int HIVEC_BIT = 14,
  parameter int DSX_BIT = 13,
  parameter int INSN_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  excStrobe_t         strobe,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [ADDR_W-1:0]  excPc,
  input  logic               excInDelay,
  input  logic [SR_W-1:0]    statusIn,
  output logic [ADDR_W-1:0]  redirectPc,
  output logic [SR_W-1:0]    statusWrData,
  output logic [ADDR_W-1:0]  haltPc,
  output logic [ADDR_W-1:0]  epcOut,
  output logic [SR_W-1:0]    esrOut,
  output logic [ADDR_W-1:0]  eearOut
);
  localparam int PAD_W = ADDR_W - CAUSE_W - VEC_SHIFT;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] vecOffset;
  logic [ADDR_W-1:0] vecAddr;
  logic [ADDR_W-1:0] epcNext;
  logic [SR_W-1:0]   srMarked;

  always_comb begin
    vecOffset = {{PAD_W{1'b0}}, excCause, {VEC_SHIFT{1'b0}}};
    vecAddr   = (statusIn[HIVEC_BIT] ? HI_BASE : '0) + vecOffset;
    epcNext   = excPc + (strobe.resume ? STEP : '0) - (excInDelay ? STEP : '0);
    srMarked  = statusIn;
    srMarked[DSX_BIT] = excInDelay;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectPc   <= '0;
      statusWrData <= '0;
      haltPc       <= '0;
      epcOut       <= '0;
      esrOut       <= '0;
      eearOut      <= '0;
    end else begin
      if (strobe.entry) begin
        redirectPc   <= vecAddr;
        statusWrData <= srMarked;
        epcOut       <= epcNext;
        esrOut       <= statusIn;
        if (strobe.illegal) eearOut <= excPc;
      end else if (strobe.rfe) begin
        redirectPc   <= epcOut;
        statusWrData <= esrOut;
      end
      if (strobe.trap) haltPc <= excPc;
    end
  end

  assert_vec_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.entry |=> (redirectPc[VEC_SHIFT-1:0] == '0));

  assert_shadow_copy_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.entry |=> (esrOut == $past(statusIn)));

  assert_rfe_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rfe |=> (redirectPc == $past(epcOut) && statusWrData == $past(esrOut)));

  assert_bad_keeps_state_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bad |=> ($stable(epcOut) && $stable(esrOut) && $stable(eearOut)));

  assert_halt_pc_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trap |=> (haltPc == $past(excPc) && $stable(epcOut)));
endmodule

// File: rtl/excEntryCtl.sv
module excEntryCtl
  import excPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SR_W = 32,
  parameter int CAUSE_W = 5,
  parameter int VEC_SHIFT = 8,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hF000_0000,
  parameter int HIVEC_BIT = 14,
  parameter int DSX_BIT = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               excReq,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [ADDR_W-1:0]  excPc,
  input  logic               excInDelay,
  input  logic [SR_W-1:0]    statusIn,
  input  logic               rfeReq,
  output logic               redirectValid,
  output logic [ADDR_W-1:0]  redirectPc,
  output logic               statusWe,
  output logic [SR_W-1:0]    statusWrData,
  output logic               delayClr,
  output logic               haltValid,
  output logic [ADDR_W-1:0]  haltPc,
  output logic               causeErr,
  output logic [ADDR_W-1:0]  epcOut,
  output logic [SR_W-1:0]    esrOut,
  output logic [ADDR_W-1:0]  eearOut
);
  excStrobe_t strobe;

  excCtrl #(.CAUSE_W(CAUSE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCause(excCause),
    .rfeReq(rfeReq), .strobe(strobe), .redirectValid(redirectValid),
    .statusWe(statusWe), .delayClr(delayClr), .haltValid(haltValid),
    .causeErr(causeErr)
  );

  excDatapath #(
    .ADDR_W(ADDR_W), .SR_W(SR_W), .CAUSE_W(CAUSE_W), .VEC_SHIFT(VEC_SHIFT),
    .HI_BASE(HI_BASE), .HIVEC_BIT(HIVEC_BIT), .DSX_BIT(DSX_BIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .excCause(excCause),
    .excPc(excPc), .excInDelay(excInDelay), .statusIn(statusIn),
    .redirectPc(redirectPc), .statusWrData(statusWrData), .haltPc(haltPc),
    .epcOut(epcOut), .esrOut(esrOut), .eearOut(eearOut)
  );

  assert_delay_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    delayClr == redirectValid);
endmodule

// File: tb/test_excEntryCtl.sv
module test_excEntryCtl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [4:0]  excCause = '0;
  logic [31:0] excPc = '0;
  logic        excInDelay = 1'b0;
  logic [31:0] statusIn = '0;
  logic        rfeReq = 1'b0;
  logic        redirectValid, statusWe, delayClr, haltValid, causeErr;
  logic [31:0] redirectPc, statusWrData, haltPc, epcOut, esrOut, eearOut;

  int tests = 0;
  int fails = 0;
  logic [31:0] mEpc = '0, mEsr = '0, mEear = '0;

  always #2.5 clk = ~clk;

  excEntryCtl i_excEntryCtl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCause(excCause),
    .excPc(excPc), .excInDelay(excInDelay), .statusIn(statusIn),
    .rfeReq(rfeReq), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .statusWe(statusWe), .statusWrData(statusWrData), .delayClr(delayClr),
    .haltValid(haltValid), .haltPc(haltPc), .causeErr(causeErr),
    .epcOut(epcOut), .esrOut(esrOut), .eearOut(eearOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit isEntry(input logic [4:0] c);
    return c >= 5'd2 && c <= 5'd13;
  endfunction
  function automatic bit isResume(input logic [4:0] c);
    return c == 5'd5 || c == 5'd8 || c == 5'd11;
  endfunction
  function automatic logic [31:0] vecOf(input logic [4:0] c, input logic [31:0] sr);
    return (sr[14] ? 32'hF000_0000 : 32'h0) + (32'(c) << 8);
  endfunction

  task automatic step(input bit req, input logic [4:0] c, input logic [31:0] pc,
                      input bit dly, input logic [31:0] sr, input bit rfe);
    bit ent, trp, bad, ret;
    logic [31:0] expPc, expSr;
    ent = req && isEntry(c);
    trp = req && c == 5'd14;
    bad = req && !ent && !trp;
    ret = rfe && !req;
    expPc = mEpc; expSr = mEsr;
    if (ent) begin
      expPc = vecOf(c, sr);
      expSr = sr; expSr[13] = dly;
      mEpc = pc + (isResume(c) ? 32'd4 : 32'd0) - (dly ? 32'd4 : 32'd0);
      mEsr = sr;
      if (c == 5'd7) mEear = pc;
    end
    @(negedge clk);
    excReq = req; excCause = c; excPc = pc; excInDelay = dly;
    statusIn = sr; rfeReq = rfe;
    @(negedge clk);
    excReq = 1'b0; rfeReq = 1'b0;
    chk("R1", "redirectValid", 32'(redirectValid), 32'(ent || ret));
    chk("R3", "statusWe", 32'(statusWe), 32'(ent || ret));
    chk("R9", "delayClr", 32'(delayClr), 32'(ent || ret));
    chk("R6", "haltValid", 32'(haltValid), 32'(trp));
    chk("R7", "causeErr", 32'(causeErr), 32'(bad));
    if (ent) begin
      chk("R1", "redirectPc", redirectPc, expPc);
      chk("R3", "statusWrData", statusWrData, expSr);
    end
    if (ret) begin
      chk("R8", "redirectPc", redirectPc, expPc);
      chk("R8", "statusWrData", statusWrData, expSr);
    end
    if (trp) chk("R6", "haltPc", haltPc, pc);
    chk("R4", "epcOut", epcOut, mEpc);
    chk("R2", "esrOut", esrOut, mEsr);
    chk("R5", "eearOut", eearOut, mEear);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    chk("R11", "outputs", {26'd0, redirectValid, statusWe, delayClr, haltValid,
        causeErr, 1'b0}, 32'd0);
    chk("R11", "epcOut", epcOut, 0);
    chk("R11", "esrOut|eear", esrOut | eearOut | redirectPc | haltPc | statusWrData, 0);
    // Directed corners
    step(1, 5'd2, 32'h0000_1000, 0, 32'h0000_0001, 0);      // R1 low base
    step(1, 5'd13, 32'h0000_2000, 0, 32'h0000_4000, 0);     // R1 high base
    step(1, 5'd5, 32'h0000_3000, 0, 32'h0000_0000, 0);      // R4 resume
    step(1, 5'd11, 32'h0000_3100, 1, 32'h0000_2000, 0);     // R4 resume+delay
    step(0, 5'd0, 32'h0, 0, 32'h0, 1);                      // R8 return
    step(1, 5'd3, 32'h0000_4000, 1, 32'h0000_4002, 0);      // R4 delay
    step(1, 5'd7, 32'h0000_5004, 0, 32'h0000_0003, 0);      // R5 illegal
    step(1, 5'd14, 32'h0000_6008, 0, 32'h0000_0000, 0);     // R6 trap
    step(1, 5'd0, 32'h0000_7000, 0, 32'hFFFF_FFFF, 0);      // R7 bad
    step(1, 5'd31, 32'h0000_7004, 1, 32'hFFFF_FFFF, 0);     // R7 bad
    step(1, 5'd15, 32'h0000_7008, 0, 32'h0, 1);             // R10 bad + rfe
    step(1, 5'd8, 32'h0000_8000, 0, 32'h0000_4000, 1);      // R10 entry + rfe
    step(0, 5'd0, 32'h0, 0, 32'h0, 1);                      // R8 return
    void'($urandom(32'd4242));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], 5'($urandom), {$urandom} & 32'hFFFF_FFFC, r[1],
           $urandom, r[3:2] == 2'b00);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule